// File: doc/BRIEF.md
# ADC Output Format Encoder

This block sits on the sample path of a 12-bit converter. Samples arrive in offset binary, one per clock, with a valid flag. Each valid sample is registered and presented in one of three codings: offset binary, two's complement or Gray code. Offset binary is passed through unchanged. Two's complement inverts the top bit. Gray code keeps the top bit and XORs every lower bit with its more significant neighbour.

The coding normally comes from a board strap that can be tied high, tied low or left floating. The strap reaches the block already resolved into a 2-bit state. A small override register, written by the serial control port's register logic, can replace the strap choice when its enable bit is set. The block reports the coding it applied to each output sample. It also has a separate registered Gray-to-offset-binary decoder, so that a round trip can be checked.

Top module: `adc_fmt_encoder`

## Requirements
- R1: With offset binary selected, `out_code` equals the captured sample unchanged, so input 0x000 gives 0x000 and input 0xFFF gives 0xFFF.
- R2: With two's complement selected, `out_code` equals the sample with bit 11 inverted and bits 10..0 unchanged.
- R3: With Gray selected, bit 11 of `out_code` equals sample bit 11. Each lower bit i equals sample bit i XOR sample bit i+1.
- R4: `dec_out` presents, one cycle after `dec_in`, the offset binary value decoded from MSB down. Bit 11 equals the Gray bit 11, and each lower bit i equals Gray bit i XOR decoded bit i+1.
- R5: With the override disabled, the strap state selects the format: 00 (tied low) selects offset binary, 01 (tied high) selects two's complement, and 10 or 11 (floating) selects Gray.
- R6: A write with `cfg_wdata[2]`=1 enables the override. Field `cfg_wdata[1:0]` then selects the format regardless of the strap: 00 offset binary, 01 two's complement, 10 Gray, 11 offset binary. A write with bit 2 clear returns control to the strap.
- R7: `out_valid` equals `in_valid` delayed by exactly one clock.
- R8: In a cycle with `in_valid` low, `out_code` and `out_fmt` keep their previous values.
- R9: `out_fmt` reports the format used for the sample in `out_code`, encoded 00 offset binary, 01 two's complement, 10 Gray. A register write takes effect from the first sample captured on a later edge. A sample captured on the same edge as the write uses the old setting, and no sample mixes two formats.
- R10: Synchronous active-high reset clears `out_code`, `out_fmt`, `out_valid`, `dec_out` and the override enable, so the strap decides the format after reset.
- R11: A mid-scale input 0x800 yields 0x800 in offset binary, 0x000 in two's complement and 0xC00 in Gray.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 12 | Offset binary sample |
| strap_state | input | 2 | Resolved strap: 00 low, 01 high, 1x floating |
| cfg_wr | input | 1 | Override register write strobe |
| cfg_wdata | input | 3 | Bit 2 override enable, bits 1..0 format field |
| dec_in | input | 12 | Gray code for the decode path |
| out_valid | output | 1 | Registered sample qualifier |
| out_code | output | 12 | Formatted sample |
| out_fmt | output | 2 | Format applied to `out_code` |
| dec_out | output | 12 | Decoded offset binary from `dec_in` |

## Verification
The assertions assume that `in_valid`, `strap_state`, `cfg_wr` and `cfg_wdata` are free of X after reset and settle before each rising edge. They also assume the strap may change on any cycle, and that a register write may coincide with a sample. The stimulus draws every input from `$urandom` with a fixed seed and drives it on the falling edge. It issues writes on about one cycle in ten, including the reserved field value 11 and writes in the same cycle as a valid sample. Directed passes cover the code extremes, mid-scale under every strap state, and an override set just before reset.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
    typedef enum logic [1:0] {
        FMT_OFFSET = 2'b00,
        FMT_TWOS   = 2'b01,
        FMT_GRAY   = 2'b10
    } fmt_e;

    localparam logic [1:0] STRAP_LOW  = 2'b00;
    localparam logic [1:0] STRAP_HIGH = 2'b01;
    localparam int unsigned CFG_W     = 3;
    localparam int unsigned CFG_EN    = 2;
endpackage

// File: rtl/adcfmt_select.sv
module adcfmt_select
    import adcfmt_pkg::*;
(
    input  logic [1:0] strap_state,
    input  logic       ovr_en,
    input  logic [1:0] ovr_fmt,
    output fmt_e       fmt
);
    fmt_e strap_fmt;
    fmt_e reg_fmt;

    always_comb begin
        unique case (strap_state)
            STRAP_LOW:  strap_fmt = FMT_OFFSET;
            STRAP_HIGH: strap_fmt = FMT_TWOS;
            default:    strap_fmt = FMT_GRAY;
        endcase
    end

    always_comb begin
        unique case (ovr_fmt)
            2'b01:   reg_fmt = FMT_TWOS;
            2'b10:   reg_fmt = FMT_GRAY;
            default: reg_fmt = FMT_OFFSET;
        endcase
    end

    assign fmt = ovr_en ? reg_fmt : strap_fmt;
endmodule

// File: rtl/adcfmt_encode.sv
module adcfmt_encode
    import adcfmt_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] bin,
    input  fmt_e         fmt,
    output logic [W-1:0] code
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] gray;
    logic [W-1:0] twos;

    assign gray[MSB] = bin[MSB];
    for (genvar i = 0; i < MSB; i++) begin : g_gray
        assign gray[i] = bin[i] ^ bin[i+1];
    end

    assign twos = {~bin[MSB], bin[MSB-1:0]};

    always_comb begin
        unique case (fmt)
            FMT_TWOS: code = twos;
            FMT_GRAY: code = gray;
            default:  code = bin;
        endcase
    end
endmodule

// File: rtl/adcfmt_gray_dec.sv
module adcfmt_gray_dec #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    localparam int unsigned MSB = W - 1;

    assign bin[MSB] = gray[MSB];
    for (genvar i = 0; i < MSB; i++) begin : g_chain
        assign bin[i] = gray[i] ^ bin[i+1];
    end
endmodule

// File: rtl/adc_fmt_encoder.sv
module adc_fmt_encoder
    import adcfmt_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [W-1:0]            in_sample,
    input  logic [1:0]              strap_state,
    input  logic                    cfg_wr,
    input  logic [CFG_W-1:0]        cfg_wdata,
    input  logic [W-1:0]            dec_in,
    output logic                    out_valid,
    output logic [W-1:0]            out_code,
    output logic [1:0]              out_fmt,
    output logic [W-1:0]            dec_out
);
    typedef struct packed {
        logic [W-1:0] code;
        logic         valid;
        fmt_e         fmt;
        logic         ovr_en;
        logic [1:0]   ovr_fmt;
        logic [W-1:0] dec;
    } state_t;

    state_t st_d, st_q;

    fmt_e         eff_fmt;
    logic [W-1:0] enc_code;
    logic [W-1:0] dec_bin;

    adcfmt_select u_sel (
        .strap_state (strap_state),
        .ovr_en      (st_q.ovr_en),
        .ovr_fmt     (st_q.ovr_fmt),
        .fmt         (eff_fmt)
    );

    adcfmt_encode #(.W(W)) u_enc (
        .bin  (in_sample),
        .fmt  (eff_fmt),
        .code (enc_code)
    );

    adcfmt_gray_dec #(.W(W)) u_dec (
        .gray (dec_in),
        .bin  (dec_bin)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.dec   = dec_bin;
        if (in_valid) begin
            st_d.code = enc_code;
            st_d.fmt  = eff_fmt;
        end
        if (cfg_wr) begin
            st_d.ovr_en  = cfg_wdata[CFG_EN];
            st_d.ovr_fmt = cfg_wdata[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_code  = st_q.code;
    assign out_fmt   = st_q.fmt;
    assign dec_out   = st_q.dec;
endmodule

// File: rtl/adc_fmt_encoder_chk.sv
module adc_fmt_encoder_chk #(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] in_sample,
    input logic         cfg_wr,
    input logic [2:0]   cfg_wdata,
    input logic [W-1:0] dec_in,
    input logic         out_valid,
    input logic [W-1:0] out_code,
    input logic [1:0]   out_fmt,
    input logic [W-1:0] dec_out
);
    localparam int unsigned MSB = W - 1;

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !in_valid) |-> ($stable(out_code) && $stable(out_fmt))); // R8

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && in_valid) && out_fmt == 2'b00) |-> out_code == $past(in_sample)); // R1

    AST_TWOS_MSB: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && in_valid) && out_fmt == 2'b01)
        |-> out_code == {~$past(in_sample[MSB]), $past(in_sample[MSB-1:0])}); // R2

    AST_GRAY_TOP: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && in_valid) && out_fmt == 2'b10) |-> out_code[MSB] == $past(in_sample[MSB])); // R3

    AST_FMT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_fmt != 2'b11); // R9

    AST_OVR_GRAY: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && cfg_wr && cfg_wdata == 3'b110, 2) && $past(!rst && !cfg_wr && in_valid))
        |-> out_fmt == 2'b10); // R6

    AST_DEC_TOP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> dec_out[MSB] == $past(dec_in[MSB])); // R4
endmodule

bind adc_fmt_encoder adc_fmt_encoder_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .dec_in    (dec_in),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_fmt   (out_fmt),
    .dec_out   (dec_out)
);

// File: tb/adc_fmt_encoder_tb_top.sv
module adc_fmt_encoder_tb_top;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_sample = '0;
    logic [1:0]   strap_state = 2'b00;
    logic         cfg_wr = 1'b0;
    logic [2:0]   cfg_wdata = '0;
    logic [W-1:0] dec_in = '0;
    logic         out_valid;
    logic [W-1:0] out_code;
    logic [1:0]   out_fmt;
    logic [W-1:0] dec_out;

    int unsigned nvec = 0;
    int unsigned nfail = 0;

    logic         m_en = 1'b0;
    logic [1:0]   m_fmt = 2'b00;
    logic [W-1:0] e_code = '0;
    logic [1:0]   e_fmt = 2'b00;
    logic         e_valid = 1'b0;
    logic [W-1:0] e_dec = '0;

    always #10 clk = ~clk;

    adc_fmt_encoder #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .strap_state(strap_state), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .dec_in(dec_in), .out_valid(out_valid), .out_code(out_code),
        .out_fmt(out_fmt), .dec_out(dec_out)
    );

    function automatic logic [1:0] strap_to_fmt(input logic [1:0] s);
        if (s == 2'b00) return 2'b00;
        if (s == 2'b01) return 2'b01;
        return 2'b10;
    endfunction

    function automatic logic [1:0] field_to_fmt(input logic [1:0] f);
        return (f == 2'b11) ? 2'b00 : f;
    endfunction

    function automatic logic [W-1:0] encode(input logic [W-1:0] b, input logic [1:0] f);
        logic [W-1:0] r;
        r = b;
        if (f == 2'b01) r[W-1] = ~b[W-1];
        if (f == 2'b10) begin
            for (int i = 0; i < W - 1; i++) r[i] = b[i] ^ b[i+1];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
        logic [W-1:0] r;
        r[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) r[i] = g[i] ^ r[i+1];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; cfg_wr = 1'b0;
        repeat (2) @(posedge clk);
        #3;
        chk("R10 valid", {11'b0, out_valid}, '0);
        chk("R10 code", out_code, '0);
        chk("R10 fmt", {10'b0, out_fmt}, '0);
        chk("R10 dec", dec_out, '0);
        m_en = 1'b0; m_fmt = 2'b00;
        e_code = '0; e_fmt = 2'b00; e_valid = 1'b0; e_dec = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic apply(input logic v, input logic [W-1:0] s, input logic [1:0] st,
                         input logic wr, input logic [2:0] wd, input logic [W-1:0] di,
                         input string tag);
        logic [1:0] f;
        string ctag, ftag;
        @(negedge clk);
        in_valid = v; in_sample = s; strap_state = st;
        cfg_wr = wr; cfg_wdata = wd; dec_in = di;
        f = m_en ? field_to_fmt(m_fmt) : strap_to_fmt(st);
        if (v) begin
            e_code = encode(s, f);
            e_fmt = f;
        end
        e_valid = v;
        e_dec = gray_to_bin(di);
        if (!v) ctag = "R8";
        else if (tag != "") ctag = tag;
        else if (f == 2'b00) ctag = "R1";
        else if (f == 2'b01) ctag = "R2";
        else ctag = "R3";
        ftag = m_en ? "R6 R9" : "R5 R9";
        if (wr) begin
            m_en = wd[2];
            m_fmt = wd[1:0];
        end
        @(posedge clk);
        #3;
        chk("R7", {11'b0, out_valid}, {11'b0, e_valid});
        chk(ctag, out_code, e_code);
        chk(ftag, {10'b0, out_fmt}, {10'b0, e_fmt});
        chk("R4", dec_out, e_dec);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0a1c));
        do_reset();

        // R11 mid-scale under each strap state
        apply(1, 12'h800, 2'b00, 0, 3'b000, 12'hC00, "R11");
        apply(1, 12'h800, 2'b01, 0, 3'b000, 12'h000, "R11");
        apply(1, 12'h800, 2'b10, 0, 3'b000, 12'h800, "R11");
        apply(1, 12'h800, 2'b11, 0, 3'b000, 12'hFFF, "R11");
        // R1 extremes
        apply(1, 12'h000, 2'b00, 0, 3'b000, 12'h001, "R1");
        apply(1, 12'hFFF, 2'b00, 0, 3'b000, 12'hAAA, "R1");
        // R9 write coincident with sample: old format applies, then Gray
        apply(1, 12'h123, 2'b01, 1, 3'b110, 12'h555, "R9");
        apply(1, 12'h123, 2'b01, 0, 3'b000, 12'h0F0, "R9");
        // R8 hold during idle
        apply(0, 12'hABC, 2'b00, 0, 3'b000, 12'h000, "");
        // R6 reserved field value maps to offset binary
        apply(1, 12'h7FF, 2'b10, 1, 3'b111, 12'h000, "R6");
        apply(1, 12'h7FF, 2'b10, 0, 3'b000, 12'h000, "R6");
        // R6 disable returns to strap
        apply(1, 12'h456, 2'b10, 1, 3'b010, 12'h000, "R6");
        apply(1, 12'h456, 2'b10, 0, 3'b000, 12'h000, "R5");
        // R10 override cleared by reset
        apply(1, 12'h321, 2'b00, 1, 3'b101, 12'h000, "R10");
        do_reset();
        apply(1, 12'h321, 2'b00, 0, 3'b000, 12'h000, "R10");

        for (int n = 0; n < 3000; n++) begin
            logic wr;
            wr = ($urandom_range(0, 9) == 0);
            apply(logic'($urandom_range(0, 3) != 0), W'($urandom),
                  2'($urandom), wr, 3'($urandom), W'($urandom), "");
        end

        finish_run();
    end
endmodule